// File: doc/BRIEF.md
# Configuration Command Decoder

This block sits behind a host control endpoint. It reads a stream of configuration command bytes, one at a time, under a valid/ready handshake. It splits the stream into frames. Each frame becomes either a register write or a register read on a built-in file of byte-wide registers. The first byte of a frame is an opcode, and the opcode fixes how long the frame is.

A write frame has four bytes: the opcode 0x5a, a key byte that must equal 0x32, the register address, and the data value. A read frame has three bytes: the opcode 0x55, a key byte whose value is not checked, and the register address. Only a read frame produces an answer. That answer is one byte holding the current contents of the addressed register, and it leaves on a separate response stream with its own valid/ready handshake. While the response waits to be taken, the decoder accepts no further input bytes. A byte that arrives where an opcode is expected but is neither 0x55 nor 0x5a is dropped. A write frame with the wrong key is consumed in full without writing anything, and it increments a wrapping error counter.

The state machine has these states: IDLE (expects an opcode), RD_KEY, RD_ADDR, RSP_WAIT (response pending), WR_KEY, WR_ADDR, WR_DATA, DROP_ADDR and DROP_DATA. Each transition fires only on an accepted byte, except the one out of RSP_WAIT:

- IDLE goes to RD_KEY on 0x55, goes to WR_KEY on 0x5a, and stays in IDLE on any other byte.
- RD_KEY goes to RD_ADDR.
- RD_ADDR goes to RSP_WAIT, and the response register loads at that point.
- RSP_WAIT goes to IDLE when the response handshake completes.
- WR_KEY goes to WR_ADDR on key 0x32. On any other key it goes to DROP_ADDR and the error counter increments.
- WR_ADDR goes to WR_DATA, and the address is captured at that point.
- WR_DATA goes to IDLE and writes the register.
- DROP_ADDR goes to DROP_DATA.
- DROP_DATA goes to IDLE.

Top module: `cfg_cmd_decoder`

## Requirements
- R1: After reset, in_ready is 1, rsp_valid is 0, err_count is 0, and every register reads back as 0x00.
- R2: A frame that starts with 0x55 is three bytes long, and its third byte is the register address. The frame yields exactly one response byte, equal to the current contents of that register.
- R3: The second byte of a read frame has no influence on the response value.
- R4: A frame that starts with 0x5a and has 0x32 as its second byte writes its fourth byte into the register addressed by its third byte. In the cycle the fourth byte is accepted, bus_wr_en is 1, bus_addr carries the third byte and bus_wr_data carries the fourth byte. A later read returns the new value.
- R5: A write frame never produces a response: rsp_valid stays 0 throughout the frame and after it.
- R6: A write frame whose second byte is not 0x32 writes nothing and consumes its remaining two bytes. It increments err_count by one, and err_count wraps modulo 2^ERR_W.
- R7: A byte that arrives where an opcode is expected and is neither 0x55 nor 0x5a is accepted and discarded. The decoder then treats the next byte as an opcode.
- R8: From the cycle after a read address byte is accepted until the response is taken, in_ready is 0 and rsp_data is held stable.
- R9: rsp_valid becomes 1 in the cycle after the read address byte is accepted. It becomes 0 in the cycle after a clock edge at which both rsp_valid and rsp_ready are 1.
- R10: The byte values 0x55 and 0x5a are taken as plain field values when they appear in the key, address or data position of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Command byte |
| in_valid | input | 1 | Command byte present |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| rsp_data | output | 8 | Read response byte |
| rsp_valid | output | 1 | Response byte present |
| rsp_ready | input | 1 | Consumer takes the response byte |
| bus_wr_en | output | 1 | Register write strobe |
| bus_addr | output | ADDR_W | Register write address |
| bus_wr_data | output | 8 | Register write data |
| err_count | output | ERR_W | Count of write frames rejected for a bad key |

## Verification
The decoder is driven with write/read pairs at the real configuration addresses. This shows whether the address byte and the data byte land in the right place, and whether the response stream returns the stored value. Reads with varied key bytes separate a decoder that ignores the read key from one that checks it. A write with a bad key, followed by a read of its address, tells a frame that was really dropped from one that was partly applied. A stray non-opcode byte, and opcode values placed in the address and data positions, expose any decoder that resynchronises on content instead of counting bytes. Holding the response back for several cycles and resetting in the middle of a frame cover the backpressure path and the reset path, and a run of bad-key frames drives the error counter through its wrap.

// File: rtl/cfgdec_pkg.sv
`timescale 1ns/1ps
package cfgdec_pkg;
    localparam int          BYTE_W   = 8;
    localparam logic [7:0]  OP_READ  = 8'h55;
    localparam logic [7:0]  OP_WRITE = 8'h5a;
    localparam logic [7:0]  WR_KEY   = 8'h32;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_KEY,
        ST_RD_ADDR,
        ST_RSP_WAIT,
        ST_WR_KEY,
        ST_WR_ADDR,
        ST_WR_DATA,
        ST_DROP_ADDR,
        ST_DROP_DATA
    } dec_state_t;
endpackage

// File: rtl/cfgdec_fsm.sv
`timescale 1ns/1ps
module cfgdec_fsm
    import cfgdec_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              rsp_done,
    output logic              rsp_load,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              key_err
);
    dec_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              take;

    assign take = in_valid && in_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured write address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              addr_q <= '0;
        else if (state_q == ST_WR_ADDR && take)  addr_q <= in_data[ADDR_W-1:0];
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take) begin
                if (in_data == OP_READ)       state_d = ST_RD_KEY;
                else if (in_data == OP_WRITE) state_d = ST_WR_KEY;
                else                          state_d = ST_IDLE;
            end
            ST_RD_KEY:    if (take) state_d = ST_RD_ADDR;
            ST_RD_ADDR:   if (take) state_d = ST_RSP_WAIT;
            ST_RSP_WAIT:  if (rsp_done) state_d = ST_IDLE;
            ST_WR_KEY: if (take) begin
                if (in_data == WR_KEY) state_d = ST_WR_ADDR;
                else                   state_d = ST_DROP_ADDR;
            end
            ST_WR_ADDR:   if (take) state_d = ST_WR_DATA;
            ST_WR_DATA:   if (take) state_d = ST_IDLE;
            ST_DROP_ADDR: if (take) state_d = ST_DROP_DATA;
            ST_DROP_DATA: if (take) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = 1'b1;
        rsp_load = 1'b0;
        wr_en    = 1'b0;
        key_err  = 1'b0;
        unique case (state_q)
            ST_RSP_WAIT: in_ready = 1'b0;
            ST_RD_ADDR:  rsp_load = in_valid;
            ST_WR_DATA:  wr_en    = in_valid;
            ST_WR_KEY:   key_err  = in_valid && (in_data != WR_KEY);
            default:     ;
        endcase
    end

    assign wr_addr = addr_q;

    // R7
    idle_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && take && in_data != OP_READ && in_data != OP_WRITE)
            |=> state_q == ST_IDLE);

    // R6
    drop_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_err |=> (state_q == ST_DROP_ADDR && !wr_en));

    // R10
    frame_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_ADDR && take) |=> state_q == ST_WR_DATA);
endmodule

// File: rtl/cfgdec_regfile.sv
`timescale 1ns/1ps
module cfgdec_regfile
    import cfgdec_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [BYTE_W-1:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                      cell_q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))         cell_q <= wr_data;
        end
        assign cells[i] = cell_q;
    end

    assign rd_data = cells[rd_addr];

    // R4
    store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cells[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/cfgdec_rsp.sv
`timescale 1ns/1ps
module cfgdec_rsp
    import cfgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    output logic [BYTE_W-1:0] rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              done
);
    assign done = rsp_valid && rsp_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else if (load) begin
            rsp_valid <= 1'b1;
            rsp_data  <= load_data;
        end else if (done) begin
            rsp_valid <= 1'b0;
        end
    end

    // R8
    hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R9
    drop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> !rsp_valid);
endmodule

// File: rtl/cfgdec_errcnt.sv
`timescale 1ns/1ps
module cfgdec_errcnt #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [ERR_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (bump) count <= count + 1'b1;
    end

    // R6
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> count == $past(count) + 1'b1);
endmodule

// File: rtl/cfg_cmd_decoder.sv
`timescale 1ns/1ps
module cfg_cmd_decoder
    import cfgdec_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [7:0]        rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              bus_wr_en,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wr_data,
    output logic [ERR_W-1:0]  err_count
);
    logic              rsp_load, rsp_done, key_err;
    logic [BYTE_W-1:0] rd_data;

    cfgdec_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .rsp_done (rsp_done),
        .rsp_load (rsp_load),
        .wr_en    (bus_wr_en),
        .wr_addr  (bus_addr),
        .key_err  (key_err)
    );

    assign bus_wr_data = in_data;

    cfgdec_regfile #(.ADDR_W(ADDR_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_en),
        .wr_addr (bus_addr),
        .wr_data (bus_wr_data),
        .rd_addr (in_data[ADDR_W-1:0]),
        .rd_data (rd_data)
    );

    cfgdec_rsp rsp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rsp_load),
        .load_data (rd_data),
        .rsp_data  (rsp_data),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .done      (rsp_done)
    );

    cfgdec_errcnt #(.ERR_W(ERR_W)) err_i (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (key_err),
        .count (err_count)
    );

    // R8
    stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !in_ready);

    // R9
    rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(in_valid && in_ready));

    // R5
    no_rsp_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_en |-> !rsp_valid);
endmodule

// File: tb/cfg_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module cfg_cmd_decoder_tb_top;
    typedef struct packed {
        logic [2:0] len;
        logic [7:0] b0, b1, b2, b3;
        logic       rd;
        logic [7:0] val;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd4, 8'h5a, 8'h32, 8'hf4, 8'h38, 1'b0, 8'h00}, // R4
        '{3'd3, 8'h55, 8'h00, 8'hf4, 8'h00, 1'b1, 8'h38}, // R2
        '{3'd4, 8'h5a, 8'h32, 8'hef, 8'h1b, 1'b0, 8'h00}, // R5
        '{3'd3, 8'h55, 8'h77, 8'hef, 8'h00, 1'b1, 8'h1b}, // R3
        '{3'd4, 8'h5a, 8'h31, 8'h4c, 8'h61, 1'b0, 8'h00}, // R6
        '{3'd3, 8'h55, 8'h32, 8'h4c, 8'h00, 1'b1, 8'h00}, // R6
        '{3'd1, 8'h12, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00}, // R7
        '{3'd4, 8'h5a, 8'h32, 8'h55, 8'h5a, 1'b0, 8'h00}, // R10
        '{3'd3, 8'h55, 8'h5a, 8'h55, 8'h00, 1'b1, 8'h5a}, // R10
        '{3'd4, 8'h5a, 8'h32, 8'h82, 8'hb0, 1'b0, 8'h00}, // R4
        '{3'd3, 8'h55, 8'hff, 8'h82, 8'h00, 1'b1, 8'hb0}, // R3
        '{3'd3, 8'h55, 8'h32, 8'h00, 8'h00, 1'b1, 8'h00}  // R1
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] rsp_data;
    logic       rsp_valid;
    logic       rsp_ready = 1'b0;
    logic       bus_wr_en;
    logic [7:0] bus_addr;
    logic [7:0] bus_wr_data;
    logic [7:0] err_count;

    int         n_checks = 0;
    int         n_fail = 0;
    int         cycles = 0;
    logic [7:0] exp_err = 8'h00;

    always #2.5 clk = ~clk;

    cfg_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wr_data(bus_wr_data), .err_count(err_count)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // present a byte from a negedge; return just before the accepting edge
    task automatic present(input logic [7:0] b);
        in_data  = b;
        in_valid = 1'b1;
        #0.5;
        while (!in_ready) begin
            @(negedge clk);
            #0.5;
        end
    endtask

    task automatic run_frame(input vec_t v);
        logic [7:0] bytes [4];
        logic good_wr;
        bytes[0] = v.b0; bytes[1] = v.b1; bytes[2] = v.b2; bytes[3] = v.b3;
        good_wr = (v.b0 == 8'h5a) && (v.b1 == 8'h32);
        if (v.b0 == 8'h5a && v.b1 != 8'h32) exp_err = exp_err + 8'h01;
        for (int i = 0; i < int'(v.len); i++) begin
            present(bytes[i]);
            if (v.b0 == 8'h5a) begin
                check(rsp_valid == 1'b0, "R5 rsp during write", {31'd0, rsp_valid}, 32'd0);
                if (i == 3)
                    check(bus_wr_en == good_wr && (!good_wr ||
                          (bus_addr == v.b2 && bus_wr_data == v.b3)),
                          "R4/R6 write strobe", {23'd0, bus_wr_en, bus_addr},
                          {23'd0, good_wr, v.b2});
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        if (v.rd) begin
            // R9: valid one cycle after the address byte
            check(rsp_valid == 1'b1, "R9 rsp_valid rise", {31'd0, rsp_valid}, 32'd1);
            check(rsp_data == v.val, "R2 response value", {24'd0, rsp_data}, {24'd0, v.val});
            check(in_ready == 1'b0, "R8 input stalled", {31'd0, in_ready}, 32'd0);
            @(negedge clk);
            @(negedge clk);
            check(rsp_valid && rsp_data == v.val, "R8 response held",
                  {23'd0, rsp_valid, rsp_data}, {23'd0, 1'b1, v.val});
            rsp_ready = 1'b1;
            @(negedge clk);
            rsp_ready = 1'b0;
            check(!rsp_valid && in_ready, "R9 response taken",
                  {30'd0, rsp_valid, in_ready}, 32'd1);
        end else begin
            check(rsp_valid == 1'b0, "R5 no response", {31'd0, rsp_valid}, 32'd0);
            check(in_ready == 1'b1, "R7 ready after frame", {31'd0, in_ready}, 32'd1);
        end
        check(err_count == exp_err, "R6 error count", {24'd0, err_count}, {24'd0, exp_err});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=hang expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #0.5;
        // R1 reset state
        check(in_ready == 1'b1 && rsp_valid == 1'b0 && err_count == 8'h00,
              "R1 reset outputs", {22'd0, in_ready, rsp_valid, err_count}, 32'h200);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) run_frame(VECS[k]);

        // R7: several junk bytes in a row, then a valid read
        for (int j = 0; j < 3; j++) run_frame('{3'd1, 8'ha5, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00});
        run_frame('{3'd3, 8'h55, 8'h12, 8'hf4, 8'h00, 1'b1, 8'h38});

        // R6: error counter wraps
        while (exp_err != 8'hff)
            run_frame('{3'd4, 8'h5a, 8'h00, 8'h4c, 8'h99, 1'b0, 8'h00});
        run_frame('{3'd4, 8'h5a, 8'h5a, 8'h4c, 8'h99, 1'b0, 8'h00});
        check(err_count == 8'h00, "R6 counter wrap", {24'd0, err_count}, 32'd0);
        run_frame('{3'd3, 8'h55, 8'h00, 8'h4c, 8'h00, 1'b1, 8'h00});

        // R1: reset in the middle of a write frame clears everything
        present(8'h5a); @(negedge clk);
        present(8'h32); @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #0.5;
        check(in_ready && !rsp_valid && err_count == 8'h00, "R1 mid-frame reset",
              {22'd0, in_ready, rsp_valid, err_count}, 32'h200);
        @(negedge clk);
        rst_n = 1'b1;
        exp_err = 8'h00;
        @(negedge clk);
        run_frame('{3'd3, 8'h55, 8'h00, 8'hf4, 8'h00, 1'b1, 8'h00});
        run_frame('{3'd3, 8'h55, 8'h00, 8'h82, 8'h00, 1'b1, 8'h00});

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule